// File: doc/BRIEF.md
# CPU Status Flag Register

This block holds the eight-bit processor status word of a small CPU core: a global interrupt enable, a one-bit copy buffer used by bit-store and bit-load operations, and the arithmetic flags half carry, sign, overflow, negative, zero and carry. The ALU hands it a flag vector with a per-flag write mask. The control unit drives single-cycle strobes for interrupt acceptance, return from interrupt, enable set and clear, bit store, and a write of the whole register.

The register value is always visible on one output bus. A bit-load result bus returns a caller-supplied destination byte with the selected bit replaced by the copy bit. The interrupt enable gates a vector of requests against a vector of per-source masks, so the core sees a request only when both the global enable and that source's mask are set. The sign flag is not stored. It is formed from the negative and overflow flags and so always equals their exclusive or.

Top module: `status_flag_reg`

## Requirements
- R1: Bit positions of `sreg_o` are fixed: 7 interrupt enable, 6 copy bit, 5 half carry, 4 sign, 3 overflow, 2 negative, 1 zero, 0 carry. After reset every bit reads 0.
- R2: A full write (`wr_en_i`) loads bits 7, 6, 5, 3, 2, 1 and 0 from `wr_data_i` at the next rising edge. Bit 4 of the written data is ignored, and bit 4 then reads `wr_data_i[3] ^ wr_data_i[2]`.
- R3: `irq_pending_o[k]` is `irq_req_i[k] & irq_mask_i[k]` when the enable bit is 1, and 0 for every k when it is 0. `irq_any_o` is the OR of `irq_pending_o`.
- R4: `irq_accept_i` clears the enable bit at the next edge, regardless of every other strobe in that cycle.
- R5: Without accept or full write, `ie_clr_i` clears the enable bit, and `ie_set_i` or `reti_i` sets it. Clear wins over set and return. A full write overrides all three.
- R6: Without a full write, `tstore_i` loads the copy bit with `tstore_src_i[bit_sel_i]`, where `bit_sel_i` is an index from 0 to 7.
- R7: `bld_o` equals `bld_dst_i` with bit `bit_sel_i` replaced by the current copy bit. The path is combinational.
- R8: Without a full write, each arithmetic flag whose `flag_we_i` bit is 1 takes the matching `flag_val_i` bit at the next edge, and a flag whose bit is 0 keeps its value. The bit order of both vectors is {H,V,N,Z,C} on bits 4..0.
- R9: A full write has priority over ALU flag updates and over bit store in the same cycle.
- R10: After any flag update, bit 4 reads the exclusive or of bits 3 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_we_i | input | 5 | Per-flag write mask {H,V,N,Z,C} |
| flag_val_i | input | 5 | ALU flag values {H,V,N,Z,C} |
| irq_accept_i | input | 1 | Interrupt accepted strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| ie_set_i | input | 1 | Set interrupt enable |
| ie_clr_i | input | 1 | Clear interrupt enable |
| tstore_i | input | 1 | Bit-store strobe |
| tstore_src_i | input | 8 | Bit-store source operand |
| bit_sel_i | input | 3 | Bit index for store and load |
| bld_dst_i | input | 8 | Bit-load destination operand |
| wr_en_i | input | 1 | Full register write strobe |
| wr_data_i | input | 8 | Full register write data |
| irq_req_i | input | NUM_IRQ | Raw interrupt requests |
| irq_mask_i | input | NUM_IRQ | Per-source interrupt masks |
| sreg_o | output | 8 | Register value |
| bld_o | output | 8 | Bit-load result |
| irq_pending_o | output | NUM_IRQ | Gated requests |
| irq_any_o | output | 1 | Any gated request |

## Verification
The bench sweeps all 32 combinations of accept, full write, clear, set and return. A wrong priority order shows up there as the enable bit left set after an accept, or as a write overwritten by a set strobe. All 1024 pairs of flag value and mask are applied from changing start states. A mask decoded in the wrong order, or a stored sign bit, then shows up as a flag that moves when it should hold, or as bit 4 disagreeing with N xor V. Every bit index is swept for store and load, which catches an off-by-one select. Every request and mask pattern is swept with the enable at both values, which catches a gate that lets requests through while the enable is 0.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int unsigned SREG_W  = 8;
  localparam int unsigned ARITH_W = 5;
  localparam int unsigned SEL_W   = $clog2(SREG_W);
  localparam int unsigned BIT_IE  = 7;
  localparam int unsigned BIT_T   = 6;
  localparam int unsigned BIT_H   = 5;
  localparam int unsigned BIT_S   = 4;
  localparam int unsigned BIT_V   = 3;
  localparam int unsigned BIT_N   = 2;
  localparam int unsigned BIT_Z   = 1;
  localparam int unsigned BIT_C   = 0;
  // index into the {H,V,N,Z,C} arithmetic vector
  localparam int unsigned AF_H = 4;
  localparam int unsigned AF_V = 3;
  localparam int unsigned AF_N = 2;
  localparam int unsigned AF_Z = 1;
  localparam int unsigned AF_C = 0;
endpackage

// File: rtl/sfr_ie_ctrl.sv
module sfr_ie_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic reti_i,
  output logic ie_o
);
  logic ie_q, ie_d;

  // accept > full write > clear > set/return
  always_comb begin
    ie_d = ie_q;
    if (accept_i)            ie_d = 1'b0;
    else if (wr_en_i)        ie_d = wr_bit_i;
    else if (clr_i)          ie_d = 1'b0;
    else if (set_i || reti_i) ie_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ie_q <= 1'b0;
    else         ie_q <= ie_d;
  end

  assign ie_o = ie_q;
endmodule

// File: rtl/sfr_tbit.sv
module sfr_tbit #(
  parameter int unsigned W = 8,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_bit_i,
  input  logic          store_i,
  input  logic [W-1:0]  src_i,
  input  logic [SW-1:0] sel_i,
  input  logic [W-1:0]  dst_i,
  output logic          t_o,
  output logic [W-1:0]  bld_o
);
  logic t_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      t_q <= 1'b0;
    else if (wr_en_i) t_q <= wr_bit_i;
    else if (store_i) t_q <= src_i[sel_i];
  end

  for (genvar b = 0; b < W; b++) begin : g_bld
    assign bld_o[b] = (sel_i == SW'(b)) ? t_q : dst_i[b];
  end

  assign t_o = t_q;
endmodule

// File: rtl/sfr_arith.sv
module sfr_arith
  import sfr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ARITH_W-1:0] wr_flags_i,
  input  logic [ARITH_W-1:0] we_i,
  input  logic [ARITH_W-1:0] val_i,
  output logic [ARITH_W-1:0] flags_o,
  output logic               sign_o
);
  logic [ARITH_W-1:0] flag_q;

  for (genvar f = 0; f < ARITH_W; f++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flag_q[f] <= 1'b0;
      else if (wr_en_i) flag_q[f] <= wr_flags_i[f];
      else if (we_i[f]) flag_q[f] <= val_i[f];
    end
  end

  assign flags_o = flag_q;
  // sign is never stored, so no write path can break it
  assign sign_o  = flag_q[AF_N] ^ flag_q[AF_V];
endmodule

// File: rtl/sfr_irq_gate.sv
module sfr_irq_gate #(
  parameter int unsigned N = 4
) (
  input  logic         ie_i,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] pending_o,
  output logic         any_o
);
  for (genvar k = 0; k < N; k++) begin : g_src
    assign pending_o[k] = ie_i & req_i[k] & mask_i[k];
  end
  assign any_o = |pending_o;
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import sfr_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ARITH_W-1:0] flag_we_i,
  input  logic [ARITH_W-1:0] flag_val_i,
  input  logic               irq_accept_i,
  input  logic               reti_i,
  input  logic               ie_set_i,
  input  logic               ie_clr_i,
  input  logic               tstore_i,
  input  logic [SREG_W-1:0]  tstore_src_i,
  input  logic [SEL_W-1:0]   bit_sel_i,
  input  logic [SREG_W-1:0]  bld_dst_i,
  input  logic               wr_en_i,
  input  logic [SREG_W-1:0]  wr_data_i,
  input  logic [NUM_IRQ-1:0] irq_req_i,
  input  logic [NUM_IRQ-1:0] irq_mask_i,
  output logic [SREG_W-1:0]  sreg_o,
  output logic [SREG_W-1:0]  bld_o,
  output logic [NUM_IRQ-1:0] irq_pending_o,
  output logic               irq_any_o
);
  logic               ie, tbit, sign;
  logic [ARITH_W-1:0] arith, wr_arith;
  logic               wr_s_unused;

  assign wr_arith    = {wr_data_i[BIT_H], wr_data_i[BIT_V], wr_data_i[BIT_N],
                        wr_data_i[BIT_Z], wr_data_i[BIT_C]};
  assign wr_s_unused = wr_data_i[BIT_S];

  sfr_ie_ctrl u_ie (
    .clk_i, .rst_ni,
    .accept_i (irq_accept_i),
    .wr_en_i,
    .wr_bit_i (wr_data_i[BIT_IE]),
    .set_i    (ie_set_i),
    .clr_i    (ie_clr_i),
    .reti_i,
    .ie_o     (ie)
  );

  sfr_tbit #(.W(SREG_W)) u_tbit (
    .clk_i, .rst_ni,
    .wr_en_i,
    .wr_bit_i (wr_data_i[BIT_T]),
    .store_i  (tstore_i),
    .src_i    (tstore_src_i),
    .sel_i    (bit_sel_i),
    .dst_i    (bld_dst_i),
    .t_o      (tbit),
    .bld_o
  );

  sfr_arith u_arith (
    .clk_i, .rst_ni,
    .wr_en_i,
    .wr_flags_i (wr_arith),
    .we_i       (flag_we_i),
    .val_i      (flag_val_i),
    .flags_o    (arith),
    .sign_o     (sign)
  );

  sfr_irq_gate #(.N(NUM_IRQ)) u_gate (
    .ie_i      (ie),
    .req_i     (irq_req_i),
    .mask_i    (irq_mask_i),
    .pending_o (irq_pending_o),
    .any_o     (irq_any_o)
  );

  assign sreg_o = {ie, tbit, arith[AF_H], sign,
                   arith[AF_V], arith[AF_N], arith[AF_Z], arith[AF_C]};
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
  parameter int unsigned NUM_IRQ = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [4:0]         flag_we_i,
  input logic               irq_accept_i,
  input logic               reti_i,
  input logic               ie_set_i,
  input logic               ie_clr_i,
  input logic               tstore_i,
  input logic [7:0]         tstore_src_i,
  input logic [2:0]         bit_sel_i,
  input logic               wr_en_i,
  input logic [7:0]         wr_data_i,
  input logic [7:0]         sreg_o,
  input logic [NUM_IRQ-1:0] irq_pending_o
);
  AST_ACCEPT_CLEARS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_accept_i |=> !sreg_o[7]); // R4
  AST_SET_OR_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_set_i || reti_i) && !irq_accept_i && !wr_en_i && !ie_clr_i |=> sreg_o[7]); // R5
  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_clr_i && !wr_en_i |=> !sreg_o[7]); // R5
  AST_GATE_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sreg_o[7] |-> irq_pending_o == '0); // R3
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && flag_we_i == 5'd0 |=> $stable({sreg_o[5], sreg_o[3:0]})); // R8
  AST_WRITE_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> sreg_o[4] == ($past(wr_data_i[3]) ^ $past(wr_data_i[2]))); // R2
  AST_TSTORE_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tstore_i && !wr_en_i |=> sreg_o[6] == $past(tstore_src_i[bit_sel_i])); // R6
endmodule

bind status_flag_reg sfr_checker #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flag_we_i     (flag_we_i),
  .irq_accept_i  (irq_accept_i),
  .reti_i        (reti_i),
  .ie_set_i      (ie_set_i),
  .ie_clr_i      (ie_clr_i),
  .tstore_i      (tstore_i),
  .tstore_src_i  (tstore_src_i),
  .bit_sel_i     (bit_sel_i),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .sreg_o        (sreg_o),
  .irq_pending_o (irq_pending_o)
);

// File: tb/status_flag_reg_tb.sv
module status_flag_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 4;

  logic            clk = 0, rst_n = 0;
  logic [4:0]      flag_we = 0, flag_val = 0;
  logic            accept = 0, reti = 0, ie_set = 0, ie_clr = 0, tstore = 0, wr_en = 0;
  logic [7:0]      tsrc = 0, bld_dst = 0, wr_data = 0;
  logic [2:0]      sel = 0;
  logic [NIRQ-1:0] req = 0, mask = 0;
  logic [7:0]      sreg, bld;
  logic [NIRQ-1:0] pend;
  logic            any;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // expected state
  logic e_i = 0, e_t = 0;
  logic [4:0] e_f = 0; // {H,V,N,Z,C}

  always #(CLK_PERIOD/2) clk = ~clk;

  status_flag_reg #(.NUM_IRQ(NIRQ)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flag_we_i(flag_we), .flag_val_i(flag_val),
    .irq_accept_i(accept), .reti_i(reti), .ie_set_i(ie_set), .ie_clr_i(ie_clr),
    .tstore_i(tstore), .tstore_src_i(tsrc), .bit_sel_i(sel), .bld_dst_i(bld_dst),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .irq_req_i(req), .irq_mask_i(mask),
    .sreg_o(sreg), .bld_o(bld), .irq_pending_o(pend), .irq_any_o(any));

  function automatic logic [7:0] exp_sreg();
    return {e_i, e_t, e_f[4], e_f[3] ^ e_f[2], e_f[3], e_f[2], e_f[1], e_f[0]};
  endfunction

  task automatic check(input string req_tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req_tag, got, exp);
    end
  endtask

  task automatic idle();
    flag_we = 0; accept = 0; reti = 0; ie_set = 0; ie_clr = 0; tstore = 0; wr_en = 0;
  endtask

  // computes next state from requirements, clocks, compares register
  task automatic tick(input string req_tag);
    logic ni, nt;
    logic [4:0] nf;
    if (accept)               ni = 1'b0;
    else if (wr_en)           ni = wr_data[7];
    else if (ie_clr)          ni = 1'b0;
    else if (ie_set || reti)  ni = 1'b1;
    else                      ni = e_i;
    if (wr_en)       nt = wr_data[6];
    else if (tstore) nt = tsrc[sel];
    else             nt = e_t;
    if (wr_en) nf = {wr_data[5], wr_data[3:0]};
    else       nf = (e_f & ~flag_we) | (flag_val & flag_we);
    @(posedge clk);
    #(CLK_PERIOD/4);
    e_i = ni; e_t = nt; e_f = nf;
    check(req_tag, 32'(sreg), 32'(exp_sreg()));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*2 + 2);
    check("R1 reset", 32'(sreg), 32'h00);
    rst_n = 1;
    @(posedge clk); #(CLK_PERIOD/4);
    check("R1 after reset", 32'(sreg), 32'h00);

    // R2: full writes, bit 4 of data ignored
    for (int d = 0; d < 256; d += 7) begin
      idle(); wr_en = 1; wr_data = 8'(d);
      tick("R2 full write");
    end
    idle();

    // R4/R5/R9: all strobe combinations from both enable states
    for (int pre = 0; pre < 2; pre++) begin
      for (int k = 0; k < 32; k++) begin
        idle(); wr_en = 1; wr_data = {pre[0], 7'h15};
        tick("R2 preset");
        idle();
        accept = k[0]; wr_en = k[1]; ie_clr = k[2]; ie_set = k[3]; reti = k[4];
        wr_data = 8'h6A ^ 8'(k * 37);
        flag_we = 5'h1F; flag_val = 5'(~k);
        tstore = 1; tsrc = 8'hFF; sel = 3'(k);
        tick(k[0] ? "R4 accept priority" : "R5 R9 strobe priority");
      end
    end
    idle();

    // R8/R10: every flag value x mask
    for (int m = 0; m < 32; m++) begin
      for (int v = 0; v < 32; v++) begin
        flag_we = 5'(m); flag_val = 5'(v);
        tick("R8 R10 masked flags");
      end
    end
    idle();

    // R6: every select, source patterns
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 4; p++) begin
        tstore = 1; sel = 3'(s);
        tsrc = (p[0] ? 8'h01 << s : ~(8'h01 << s)) ^ (p[1] ? 8'h00 : 8'h00);
        tick("R6 bit store");
      end
    end
    idle();

    // R7: every select with T at both values
    for (int tv = 0; tv < 2; tv++) begin
      wr_en = 1; wr_data = {1'b0, tv[0], 6'h00};
      tick("R2 set T");
      idle();
      for (int s = 0; s < 8; s++) begin
        for (int d = 0; d < 256; d += 51) begin
          logic [7:0] e;
          sel = 3'(s); bld_dst = 8'(d);
          e = 8'(d); e[s] = tv[0];
          #1;
          check("R7 bit load", 32'(bld), 32'(e));
        end
      end
    end

    // R3: every request x mask with enable at both values
    for (int ie = 0; ie < 2; ie++) begin
      idle();
      if (ie == 1) ie_set = 1; else ie_clr = 1;
      tick("R5 enable set/clear");
      idle();
      for (int r = 0; r < 16; r++) begin
        for (int mk = 0; mk < 16; mk++) begin
          logic [NIRQ-1:0] ep;
          req = 4'(r); mask = 4'(mk);
          ep = ie[0] ? 4'(r & mk) : 4'b0;
          #1;
          check("R3 pending", 32'(pend), 32'(ep));
          check("R3 any", 32'(any), 32'(|ep));
        end
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule